// File: doc/BRIEF.md
# Receive Idle Timeout Detector

This block sits beside a serial receiver and detects a silent gap on the line after a character has arrived. Software uses it to recognise the end of a frame whose length is not known in advance. A down-counter is loaded with a programmable bit-period count whenever a character is received. The counter steps down by one on each bit-period tick from the baud generator. When it runs out, a sticky status flag is raised, and that flag drives an interrupt request when the interrupt is enabled.

A start command clears the flag and stops the counter. The counter then stays stopped until the next received character, so one idle gap gives exactly one event and an idle line gives no repeated alarms. A programmed period of zero turns the function off. All pins are plain control and status strobes or levels. There is no data stream, so no valid/ready handshake exists and the block never applies back-pressure.

Top module: `rx_idle_timeout`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `idle_flag` and `idle_irq` are 0.
- R2: A `idle_period` of zero disables detection. In that case `idle_flag` never rises, the counter is stopped at once even partway through a countdown, and a received character does not start it.
- R3: The counter moves only on cycles in which `bit_tick` is 1. After a reload with value N (N > 0), `idle_flag` becomes 1 at the clock edge that samples the N-th such tick, and not earlier.
- R4: A `char_rcvd` pulse reloads the counter with the current `idle_period` and starts the countdown again from the full value.
- R5: When the countdown reaches zero, `idle_flag` is set and the counter stops.
- R6: After reset the counter is stopped. `bit_tick` pulses have no effect until the first `char_rcvd` with a non-zero `idle_period`.
- R7: `idle_flag` is sticky. It holds 1 through further ticks and characters, and only a `start_cmd` pulse clears it. The flag is 0 from the edge that samples `start_cmd`.
- R8: `start_cmd` also stops the counter. Ticks then have no effect until the next `char_rcvd`, and a full countdown of `idle_period` ticks starts from that character. If `start_cmd` and `char_rcvd` occur in the same cycle, the flag is cleared and the countdown starts.
- R9: `idle_irq` equals `idle_flag AND irq_enable` as sampled one clock earlier (one register of latency).
- R10: If `char_rcvd` and `bit_tick` occur in the same cycle, the reload takes priority and that tick is not counted.
- R11: A change of a non-zero `idle_period` during a countdown does not alter that countdown. The new value is used from the next reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_tick | input | 1 | One-cycle pulse per bit period |
| char_rcvd | input | 1 | One-cycle pulse when a character is received |
| start_cmd | input | 1 | One-cycle pulse: clear flag and stop the counter |
| idle_period | input | CNT_W (16) | Timeout length in bit periods; 0 disables |
| irq_enable | input | 1 | Interrupt enable level |
| idle_flag | output | 1 | Sticky timeout status |
| idle_irq | output | 1 | Registered interrupt request |

## Verification
The embedded properties assume that `bit_tick`, `char_rcvd` and `start_cmd` are single-cycle strobes sampled synchronously, and that `idle_period` may change on any cycle. The properties themselves do not rely on the strobes being mutually exclusive. The stimulus drives every input on the falling edge and sweeps the period over a small range with varied gaps between ticks. It also aims deliberate collisions of character, tick and start pulses at the boundary cycle of a countdown. The expected flag cycle is computed in the bench from the tick count alone.

// File: rtl/rx_idle_timeout_pkg.sv
package rx_idle_timeout_pkg;
  localparam int unsigned DEF_CNT_W = 16;

  typedef enum logic {
    CNT_PARKED  = 1'b0,
    CNT_RUNNING = 1'b1
  } cnt_state_e;
endpackage

// File: rtl/rx_idle_countdown.sv
module rx_idle_countdown
  import rx_idle_timeout_pkg::*;
#(
  parameter int unsigned CNT_W = DEF_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_tick,
  input  logic             char_rcvd,
  input  logic             start_cmd,
  input  logic [CNT_W-1:0] idle_period,
  output logic             expire,
  output logic             running
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  cnt_state_e       state_q;
  logic [CNT_W-1:0] count_q;
  logic             period_nz;
  logic             step;

  assign period_nz = |idle_period;
  assign step      = (state_q == CNT_RUNNING) && bit_tick && !char_rcvd
                     && !start_cmd && period_nz;
  assign expire    = step && (count_q == ONE);
  assign running   = (state_q == CNT_RUNNING);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CNT_PARKED;
      count_q <= '0;
    end else if (char_rcvd) begin
      count_q <= idle_period;
      state_q <= period_nz ? CNT_RUNNING : CNT_PARKED;
    end else if (start_cmd || !period_nz) begin
      state_q <= CNT_PARKED;
    end else if (step) begin
      count_q <= count_q - ONE;
      if (count_q == ONE) state_q <= CNT_PARKED;
    end
  end

  // R4
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (char_rcvd && period_nz) |=> (running && count_q == $past(idle_period)));

  // R3
  step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && bit_tick && !char_rcvd && !start_cmd && period_nz && count_q > ONE)
      |=> (running && count_q == $past(count_q) - ONE));

  // R8
  park_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !char_rcvd) |=> (!running && $stable(count_q)));

  // R2
  zero_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_period == '0) |=> !running);

  // R5
  expire_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> (!running && count_q == '0));
endmodule

// File: rtl/rx_idle_status.sv
module rx_idle_status (
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  input  logic start_cmd,
  input  logic irq_enable,
  output logic idle_flag,
  output logic idle_irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_flag <= 1'b0;
    end else if (start_cmd) begin
      idle_flag <= 1'b0;
    end else if (expire) begin
      idle_flag <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idle_irq <= 1'b0;
    else        idle_irq <= idle_flag && irq_enable;
  end

  // R7
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_cmd |=> !idle_flag);

  // R7
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_flag && !start_cmd) |=> idle_flag);

  // R9
  irq_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (idle_irq == $past(idle_flag && irq_enable)));
endmodule

// File: rtl/rx_idle_timeout.sv
module rx_idle_timeout
  import rx_idle_timeout_pkg::*;
#(
  parameter int unsigned CNT_W = DEF_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_tick,
  input  logic             char_rcvd,
  input  logic             start_cmd,
  input  logic [CNT_W-1:0] idle_period,
  input  logic             irq_enable,
  output logic             idle_flag,
  output logic             idle_irq
);
  logic expire;
  logic running;

  rx_idle_countdown #(.CNT_W(CNT_W)) i_countdown (
    .clk         (clk),
    .rst_n       (rst_n),
    .bit_tick    (bit_tick),
    .char_rcvd   (char_rcvd),
    .start_cmd   (start_cmd),
    .idle_period (idle_period),
    .expire      (expire),
    .running     (running)
  );

  rx_idle_status i_status (
    .clk        (clk),
    .rst_n      (rst_n),
    .expire     (expire),
    .start_cmd  (start_cmd),
    .irq_enable (irq_enable),
    .idle_flag  (idle_flag),
    .idle_irq   (idle_irq)
  );

  // R2
  zero_no_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_period == '0 && !idle_flag) |=> !idle_flag);

  // R5
  flag_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !idle_flag) |=> !idle_flag);

  // R10
  reload_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (char_rcvd && !idle_flag) |=> !idle_flag);
endmodule

// File: tb/test_rx_idle_timeout.sv
module test_rx_idle_timeout;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bit_tick = 1'b0;
  logic        char_rcvd = 1'b0;
  logic        start_cmd = 1'b0;
  logic [15:0] idle_period = '0;
  logic        irq_enable = 1'b0;
  logic        idle_flag;
  logic        idle_irq;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  rx_idle_timeout i_rx_idle_timeout (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .char_rcvd(char_rcvd),
    .start_cmd(start_cmd), .idle_period(idle_period), .irq_enable(irq_enable),
    .idle_flag(idle_flag), .idle_irq(idle_irq)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // one clock with the given strobes, ending on the next falling edge
  task automatic cyc(bit t, bit c, bit s);
    bit_tick = t; char_rcvd = c; start_cmd = s;
    @(negedge clk);
    bit_tick = 0; char_rcvd = 0; start_cmd = 0;
  endtask

  task automatic ticks(int n, int gap);
    for (int i = 0; i < n; i++) begin
      cyc(1, 0, 0);
      repeat (gap) @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    check("R1 flag in reset", idle_flag, 0);
    check("R1 irq in reset", idle_irq, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 flag after reset", idle_flag, 0);
    check("R1 irq after reset", idle_irq, 0);

    // R6: parked after reset
    idle_period = 16'd3;
    ticks(10, 0);
    check("R6 no count before first char", idle_flag, 0);

    // R3 R5 R9 sweep over period and tick gap
    for (int n = 1; n <= 6; n++) begin
      for (int g = 0; g <= 2; g++) begin
        idle_period = 16'(n);
        irq_enable  = (g != 1);
        cyc(0, 0, 1);
        cyc(0, 1, 0);
        ticks(n - 1, g);
        check("R3 flag before last tick", idle_flag, 0);
        cyc(1, 0, 0);
        check("R5 flag on Nth tick", idle_flag, 1);
        check("R9 irq lags flag", idle_irq, 0);
        @(negedge clk);
        check("R9 irq equals flag and enable", idle_irq, 32'(irq_enable));
      end
    end

    // R7 sticky, then start_cmd clears; R8 parked after clear
    idle_period = 16'd4; irq_enable = 1'b1;
    ticks(5, 1);
    cyc(0, 0, 0);
    check("R7 flag sticky", idle_flag, 1);
    cyc(0, 0, 1);
    check("R7 start clears flag", idle_flag, 0);
    ticks(20, 0);
    check("R8 parked after start", idle_flag, 0);
    @(negedge clk);
    check("R9 irq low after clear", idle_irq, 0);
    cyc(0, 1, 0);
    ticks(3, 0);
    check("R8 resume full count pre", idle_flag, 0);
    ticks(1, 0);
    check("R8 resume full count", idle_flag, 1);

    // R8 start and char in the same cycle
    cyc(0, 1, 1);
    check("R8 clear with char", idle_flag, 0);
    ticks(3, 0);
    check("R8 char with start counts pre", idle_flag, 0);
    ticks(1, 0);
    check("R8 char with start counts", idle_flag, 1);

    // R4 reload mid countdown
    idle_period = 16'd5;
    cyc(0, 0, 1);
    cyc(0, 1, 0);
    ticks(4, 0);
    cyc(0, 1, 0);
    ticks(4, 1);
    check("R4 reload restarts count", idle_flag, 0);
    ticks(1, 0);
    check("R4 expiry after reload", idle_flag, 1);

    // R10 char and tick same cycle
    cyc(0, 0, 1);
    cyc(0, 1, 0);
    ticks(4, 0);
    cyc(1, 1, 0);
    check("R10 reload wins over tick", idle_flag, 0);
    ticks(4, 0);
    check("R10 tick not counted", idle_flag, 0);
    ticks(1, 0);
    check("R10 full count after collision", idle_flag, 1);

    // R11 new period takes effect at next reload
    cyc(0, 0, 1);
    idle_period = 16'd5;
    cyc(0, 1, 0);
    ticks(2, 0);
    idle_period = 16'd2;
    ticks(2, 0);
    check("R11 old period still used", idle_flag, 0);
    ticks(1, 0);
    check("R11 old period expiry", idle_flag, 1);
    cyc(0, 0, 1);
    cyc(0, 1, 0);
    ticks(2, 0);
    check("R11 new period at reload", idle_flag, 1);

    // R2 zero disables at reload and mid countdown
    cyc(0, 0, 1);
    idle_period = 16'd0;
    cyc(0, 1, 0);
    ticks(30, 0);
    check("R2 zero period no flag", idle_flag, 0);
    idle_period = 16'd3;
    cyc(0, 1, 0);
    ticks(1, 0);
    idle_period = 16'd0;
    ticks(5, 0);
    idle_period = 16'd3;
    ticks(5, 0);
    check("R2 zero stops countdown", idle_flag, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule